// File: doc/BRIEF.md
# ADC Output Test Pattern Generator

This block sits on the sample path between a data converter and its output pins. On every encode strobe it registers one output word. That word is either the live converter sample or a synthetic test word. A 4-bit mode code and a 2-bit sequencing code select the source. Both codes are loaded together through a single configuration write strobe.

The synthetic sources are:
- three fixed levels (midscale, positive full scale and negative full scale);
- a two-phase checkerboard;
- words from an external pseudo-noise generator, one long-sequence input and one short-sequence input;
- two programmable user patterns.

Each user pattern is assembled from a high byte and a low byte, left-justified into the output width. A sequencer plays the user patterns in one of four ways: steady, alternating, single shot, or pair shot. The last two force zeros once they finish.

An output-format select chooses offset binary or two's complement. It applies to the fixed levels and to the pseudo-noise words. Logical patterns (checkerboard and user patterns) ignore it, and so does live data.

Top module: `adc_tpg`

## Requirements
- R1: During reset and after it, `dout` is 0. The loaded mode is normal (0000) and the sequence step and phase are at their start.
- R2: `dout` changes only on a clock edge where `enc_stb` is 1, and it shows the new word on the next cycle. Without a strobe it holds, whatever the data inputs do.
- R3: Mode 0000 passes `adc_word` unchanged. The unassigned codes 0111 and 1001 to 1111 behave the same way.
- R4: Mode 0001 gives midscale, 0010 gives positive full scale and 0011 gives negative full scale.
  - With `fmt_twos`=0 (offset binary) these are 0x2000, 0x3FFF and 0x0000.
  - With `fmt_twos`=1 (two's complement) they are 0x0000, 0x1FFF and 0x2000.
- R5: Mode 0100 outputs 0x2AAA, then 0x1555, alternating on successive strobes. It starts at 0x2AAA after reset or after a configuration write, and it ignores `fmt_twos`.
- R6: Mode 0101 outputs `pn_long_word` and mode 0110 outputs `pn_short_word`. Both are taken as offset binary, and the MSB is inverted when `fmt_twos`=1.
- R7: A user pattern word is {hi[7:0], lo[7:2]}, the 16-bit byte pair left-justified to 14 bits. Mode 1000 selects user patterns.
- R8: In mode 1000 with sequencing 00, user pattern 1 is output on every strobe.
- R9: With sequencing 01, patterns 1 and 2 alternate on successive strobes, starting with pattern 1.
- R10: With sequencing 10, pattern 1 is output on the first strobe and zero on every later strobe.
- R11: With sequencing 11, pattern 1 is output on the first strobe, pattern 2 on the second and zero on every later strobe.
- R12: A configuration write (`cfg_we`=1) loads `cfg_mode` and `cfg_seq` and restarts the sequence step and phase, even if the codes are unchanged. A strobe in the same cycle as the write is served with the configuration and step that were in force before the write.
- R13: User pattern outputs do not depend on `fmt_twos`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_stb | input | 1 | One-cycle encode strobe, one per sample |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 4 | Mode code loaded on write |
| cfg_seq | input | 2 | Sequencing code loaded on write |
| fmt_twos | input | 1 | 1 = two's complement, 0 = offset binary |
| adc_word | input | 14 | Live converter sample |
| pn_long_word | input | 14 | Long pseudo-noise word |
| pn_short_word | input | 14 | Short pseudo-noise word |
| pat1_hi | input | 8 | User pattern 1, high byte |
| pat1_lo | input | 8 | User pattern 1, low byte |
| pat2_hi | input | 8 | User pattern 2, high byte |
| pat2_lo | input | 8 | User pattern 2, low byte |
| dout | output | 14 | Registered output word |

## Verification
A wrong sequence step or phase shows up on the strobe right after the fault. In that case, a one-shot stream delivers pattern 2 or zeros too early, or the alternation and checkerboard start on the wrong phase after a write. A wrong loaded mode corrupts every following strobed word, not only one of them. A missing restart shows only when a write lands mid-sequence, so the stimulus rewrites identical codes part way through each stream. The reference model is compared against `dout` on every cycle, so a word that changes without a strobe is caught in the cycle after it changes.

// File: rtl/adc_tpg_pkg.sv
package adc_tpg_pkg;

    localparam logic [3:0] MODE_NORMAL   = 4'b0000;
    localparam logic [3:0] MODE_MID      = 4'b0001;
    localparam logic [3:0] MODE_POS_FS   = 4'b0010;
    localparam logic [3:0] MODE_NEG_FS   = 4'b0011;
    localparam logic [3:0] MODE_CHECKER  = 4'b0100;
    localparam logic [3:0] MODE_PN_LONG  = 4'b0101;
    localparam logic [3:0] MODE_PN_SHORT = 4'b0110;
    localparam logic [3:0] MODE_USER     = 4'b1000;

    localparam logic [1:0] SEQ_STEADY = 2'b00;
    localparam logic [1:0] SEQ_ALT    = 2'b01;
    localparam logic [1:0] SEQ_ONE    = 2'b10;
    localparam logic [1:0] SEQ_PAIR   = 2'b11;

    localparam logic [1:0] STEP_DONE = 2'd2;

    typedef struct packed {
        logic [3:0] mode;
        logic [1:0] seq;
        logic [1:0] step;
        logic       phase;
    } ctrl_t;

endpackage

// File: rtl/adc_tpg_ctrl.sv
module adc_tpg_ctrl
    import adc_tpg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enc_stb,
    input  logic       cfg_we,
    input  logic [3:0] cfg_mode,
    input  logic [1:0] cfg_seq,
    output ctrl_t      ctrl
);

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (enc_stb) begin
            if (ctrl_q.step != STEP_DONE) begin
                ctrl_d.step = ctrl_q.step + 2'd1;
            end
            ctrl_d.phase = ~ctrl_q.phase;
        end
        if (cfg_we) begin
            ctrl_d.mode  = cfg_mode;
            ctrl_d.seq   = cfg_seq;
            ctrl_d.step  = '0;
            ctrl_d.phase = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl = ctrl_q;

endmodule

// File: rtl/adc_tpg_levels.sv
module adc_tpg_levels #(
    parameter int DW = 14
) (
    input  logic          fmt_twos,
    input  logic [DW-1:0] pn_long_word,
    input  logic [DW-1:0] pn_short_word,
    output logic [DW-1:0] lvl_mid,
    output logic [DW-1:0] lvl_pos,
    output logic [DW-1:0] lvl_neg,
    output logic [DW-1:0] pn_long_fmt,
    output logic [DW-1:0] pn_short_fmt
);

    localparam logic [DW-1:0] MSB_ONLY = {1'b1, {(DW-1){1'b0}}};

    logic [DW-1:0] flip;

    always_comb begin
        flip         = fmt_twos ? MSB_ONLY : '0;
        lvl_mid      = MSB_ONLY ^ flip;
        lvl_pos      = {DW{1'b1}} ^ flip;
        lvl_neg      = flip;
        pn_long_fmt  = pn_long_word ^ flip;
        pn_short_fmt = pn_short_word ^ flip;
    end

endmodule

// File: rtl/adc_tpg_userpat.sv
module adc_tpg_userpat
    import adc_tpg_pkg::*;
#(
    parameter int DW = 14,
    parameter int BW = 8
) (
    input  logic [BW-1:0] pat1_hi,
    input  logic [BW-1:0] pat1_lo,
    input  logic [BW-1:0] pat2_hi,
    input  logic [BW-1:0] pat2_lo,
    input  logic [1:0]    seq,
    input  logic [1:0]    step,
    input  logic          phase,
    output logic [DW-1:0] user_word
);

    localparam int PW = 2 * BW;

    logic [PW-1:0] full1, full2;
    logic [DW-1:0] word1, word2;

    assign full1 = {pat1_hi, pat1_lo};
    assign full2 = {pat2_hi, pat2_lo};
    assign word1 = full1[PW-1 -: DW];
    assign word2 = full2[PW-1 -: DW];

    generate
        if (PW > DW) begin : g_trim
            logic unused_lsbs;
            assign unused_lsbs = ^{full1[PW-DW-1:0], full2[PW-DW-1:0]};
        end
    endgenerate

    always_comb begin
        user_word = '0;
        unique case (seq)
            SEQ_STEADY: user_word = word1;
            SEQ_ALT:    user_word = phase ? word2 : word1;
            SEQ_ONE:    user_word = (step == 2'd0) ? word1 : '0;
            SEQ_PAIR: begin
                if (step == 2'd0)      user_word = word1;
                else if (step == 2'd1) user_word = word2;
                else                   user_word = '0;
            end
            default:    user_word = '0;
        endcase
    end

endmodule

// File: rtl/adc_tpg.sv
module adc_tpg
    import adc_tpg_pkg::*;
#(
    parameter int DW = 14,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enc_stb,
    input  logic          cfg_we,
    input  logic [3:0]    cfg_mode,
    input  logic [1:0]    cfg_seq,
    input  logic          fmt_twos,
    input  logic [DW-1:0] adc_word,
    input  logic [DW-1:0] pn_long_word,
    input  logic [DW-1:0] pn_short_word,
    input  logic [BW-1:0] pat1_hi,
    input  logic [BW-1:0] pat1_lo,
    input  logic [BW-1:0] pat2_hi,
    input  logic [BW-1:0] pat2_lo,
    output logic [DW-1:0] dout
);

    ctrl_t         ctrl;
    logic [3:0]    cur_mode;
    logic [1:0]    cur_seq;
    logic [1:0]    cur_step;
    logic          cur_phase;
    logic [DW-1:0] lvl_mid, lvl_pos, lvl_neg, pn_long_fmt, pn_short_fmt;
    logic [DW-1:0] user_word;
    logic [DW-1:0] cb_even, cb_odd;
    logic [DW-1:0] dout_d, dout_q;

    adc_tpg_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .enc_stb  (enc_stb),
        .cfg_we   (cfg_we),
        .cfg_mode (cfg_mode),
        .cfg_seq  (cfg_seq),
        .ctrl     (ctrl)
    );

    assign cur_mode  = ctrl.mode;
    assign cur_seq   = ctrl.seq;
    assign cur_step  = ctrl.step;
    assign cur_phase = ctrl.phase;

    adc_tpg_levels #(.DW(DW)) u_levels (
        .fmt_twos      (fmt_twos),
        .pn_long_word  (pn_long_word),
        .pn_short_word (pn_short_word),
        .lvl_mid       (lvl_mid),
        .lvl_pos       (lvl_pos),
        .lvl_neg       (lvl_neg),
        .pn_long_fmt   (pn_long_fmt),
        .pn_short_fmt  (pn_short_fmt)
    );

    adc_tpg_userpat #(.DW(DW), .BW(BW)) u_userpat (
        .pat1_hi   (pat1_hi),
        .pat1_lo   (pat1_lo),
        .pat2_hi   (pat2_hi),
        .pat2_lo   (pat2_lo),
        .seq       (cur_seq),
        .step      (cur_step),
        .phase     (cur_phase),
        .user_word (user_word)
    );

    // Checkerboard: the MSB is set in the first phase, then the bits alternate.
    generate
        for (genvar i = 0; i < DW; i++) begin : g_cb
            assign cb_even[i] = ((i % 2) == ((DW - 1) % 2));
            assign cb_odd[i]  = ((i % 2) != ((DW - 1) % 2));
        end
    endgenerate

    always_comb begin
        dout_d = dout_q;
        if (enc_stb) begin
            case (cur_mode)
                MODE_MID:      dout_d = lvl_mid;
                MODE_POS_FS:   dout_d = lvl_pos;
                MODE_NEG_FS:   dout_d = lvl_neg;
                MODE_CHECKER:  dout_d = cur_phase ? cb_odd : cb_even;
                MODE_PN_LONG:  dout_d = pn_long_fmt;
                MODE_PN_SHORT: dout_d = pn_short_fmt;
                MODE_USER:     dout_d = user_word;
                default:       dout_d = adc_word;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0;
        end else begin
            dout_q <= dout_d;
        end
    end

    assign dout = dout_q;

endmodule

// File: rtl/adc_tpg_chk.sv
module adc_tpg_chk #(
    parameter int DW = 14
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enc_stb,
    input logic          fmt_twos,
    input logic [DW-1:0] adc_word,
    input logic [DW-1:0] dout,
    input logic [3:0]    cur_mode,
    input logic [1:0]    cur_seq,
    input logic [1:0]    cur_step,
    input logic          cur_phase
);

    localparam logic [DW-1:0] MID_OB = {1'b1, {(DW-1){1'b0}}};

    logic [DW-1:0] cb_a;
    always_comb begin
        for (int i = 0; i < DW; i++) begin
            cb_a[i] = ((i % 2) == ((DW - 1) % 2));
        end
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_stb |=> $stable(dout));

    p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_stb && cur_mode == 4'b0000) |=> dout == $past(adc_word));

    p_mid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_stb && cur_mode == 4'b0001) |=> dout == ($past(fmt_twos) ? '0 : MID_OB));

    p_cb_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_stb && cur_mode == 4'b0100 && !cur_phase) |=> dout == cb_a);

    p_cb_other_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_stb && cur_mode == 4'b0100 && cur_phase) |=> dout == ~cb_a);

    p_zero_tail_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_stb && cur_mode == 4'b1000 && cur_seq[1] && cur_step == 2'd2) |=> dout == '0);

endmodule

bind adc_tpg adc_tpg_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enc_stb   (enc_stb),
    .fmt_twos  (fmt_twos),
    .adc_word  (adc_word),
    .dout      (dout),
    .cur_mode  (cur_mode),
    .cur_seq   (cur_seq),
    .cur_step  (cur_step),
    .cur_phase (cur_phase)
);

// File: tb/tb_adc_tpg.sv
module tb_adc_tpg;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        enc_stb, cfg_we, fmt_twos;
    logic [3:0]  cfg_mode;
    logic [1:0]  cfg_seq;
    logic [13:0] adc_word, pn_long_word, pn_short_word;
    logic [7:0]  pat1_hi, pat1_lo, pat2_hi, pat2_lo;
    logic [13:0] dout;

    int checks = 0;
    int fails  = 0;

    // Reference model state
    int          m_mode, m_seq, m_step;
    bit          m_phase;
    logic [13:0] exp_word;

    always #4 clk = ~clk;

    adc_tpg dut (
        .clk(clk), .rst_n(rst_n), .enc_stb(enc_stb), .cfg_we(cfg_we),
        .cfg_mode(cfg_mode), .cfg_seq(cfg_seq), .fmt_twos(fmt_twos),
        .adc_word(adc_word), .pn_long_word(pn_long_word),
        .pn_short_word(pn_short_word), .pat1_hi(pat1_hi), .pat1_lo(pat1_lo),
        .pat2_hi(pat2_hi), .pat2_lo(pat2_lo), .dout(dout)
    );

    function automatic logic [13:0] ref_word();
        logic [13:0] u1, u2;
        u1 = {pat1_hi, pat1_lo[7:2]};
        u2 = {pat2_hi, pat2_lo[7:2]};
        case (m_mode)
            1: return fmt_twos ? 14'h0000 : 14'h2000;
            2: return fmt_twos ? 14'h1FFF : 14'h3FFF;
            3: return fmt_twos ? 14'h2000 : 14'h0000;
            4: return m_phase ? 14'h1555 : 14'h2AAA;
            5: return pn_long_word ^ (fmt_twos ? 14'h2000 : 14'h0000);
            6: return pn_short_word ^ (fmt_twos ? 14'h2000 : 14'h0000);
            8: begin
                case (m_seq)
                    0: return u1;
                    1: return m_phase ? u2 : u1;
                    2: return (m_step == 0) ? u1 : 14'h0000;
                    default: return (m_step == 0) ? u1 : (m_step == 1) ? u2 : 14'h0000;
                endcase
            end
            default: return adc_word;
        endcase
    endfunction

    task automatic check(input string tag);
        checks++;
        if (dout !== exp_word) begin
            fails++;
            $display("FAIL %s: dout=%h expected=%h", tag, dout, exp_word);
        end
    endtask

    // Called at a negative edge: drive inputs, advance the model, check one cycle later.
    task automatic step(input bit stb, input bit we, input int md, input int sq, input string tag);
        enc_stb       = stb;
        cfg_we        = we;
        cfg_mode      = md[3:0];
        cfg_seq       = sq[1:0];
        adc_word      = 14'($urandom);
        pn_long_word  = 14'($urandom);
        pn_short_word = 14'($urandom);
        if (stb) exp_word = ref_word();
        if (we) begin
            m_mode = md; m_seq = sq; m_step = 0; m_phase = 0;
        end else if (stb) begin
            if (m_step < 2) m_step++;
            m_phase = ~m_phase;
        end
        @(negedge clk);
        check(tag);
    endtask

    task automatic cfg(input int md, input int sq, input string tag);
        step(0, 1, md, sq, tag);
    endtask

    task automatic strobes(input int n, input int md, input int sq, input string tag);
        for (int i = 0; i < n; i++) step(1, 0, md, sq, tag);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 0; enc_stb = 0; cfg_we = 0; cfg_mode = 0; cfg_seq = 0; fmt_twos = 0;
        adc_word = 0; pn_long_word = 0; pn_short_word = 0;
        pat1_hi = 8'hC3; pat1_lo = 8'h5B; pat2_hi = 8'h1E; pat2_lo = 8'hA6;
        m_mode = 0; m_seq = 0; m_step = 0; m_phase = 0; exp_word = '0;
        repeat (3) @(negedge clk);
        check("R1");
        rst_n = 1;
        step(0, 0, 0, 0, "R1");
        strobes(3, 0, 0, "R1");

        // R2: no strobe holds the word while the data inputs change
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, "R2");

        // R3: normal and unassigned codes
        strobes(4, 0, 0, "R3");
        cfg(7, 0, "R3"); strobes(3, 7, 0, "R3");
        cfg(9, 2, "R3"); strobes(3, 9, 2, "R3");
        cfg(15, 3, "R3"); strobes(3, 15, 3, "R3");

        // R4: fixed levels in both formats
        for (int f = 0; f < 2; f++) begin
            fmt_twos = f[0];
            for (int m = 1; m <= 3; m++) begin
                cfg(m, 0, "R4"); strobes(2, m, 0, "R4");
            end
        end

        // R5: checkerboard, format ignored, gaps hold
        cfg(4, 0, "R5");
        fmt_twos = 0; strobes(3, 4, 0, "R5");
        step(0, 0, 4, 0, "R5");
        fmt_twos = 1; strobes(3, 4, 0, "R5");
        cfg(4, 0, "R5"); strobes(2, 4, 0, "R5");

        // R6: PN pass-through with format
        for (int f = 0; f < 2; f++) begin
            fmt_twos = f[0];
            cfg(5, 0, "R6"); strobes(3, 5, 0, "R6");
            cfg(6, 0, "R6"); strobes(3, 6, 0, "R6");
        end

        // R7/R8: steady user pattern 1, then new bytes
        fmt_twos = 0;
        cfg(8, 0, "R8"); strobes(3, 8, 0, "R8");
        pat1_hi = 8'h7F; pat1_lo = 8'hFF; strobes(2, 8, 0, "R7");
        pat1_hi = 8'h80; pat1_lo = 8'h03; strobes(2, 8, 0, "R7");

        // R9: alternation, restarted mid-stream by R12
        cfg(8, 1, "R9"); strobes(5, 8, 1, "R9");
        cfg(8, 1, "R12"); strobes(3, 8, 1, "R12");

        // R10: single shot then zeros, restart
        cfg(8, 2, "R10"); strobes(4, 8, 2, "R10");
        step(0, 0, 8, 2, "R10");
        cfg(8, 2, "R12"); strobes(3, 8, 2, "R12");

        // R11: pair shot then zeros, restart
        cfg(8, 3, "R11"); strobes(5, 8, 3, "R11");
        cfg(8, 3, "R12"); strobes(3, 8, 3, "R12");

        // R12: write in the same cycle as a strobe uses the old setting
        cfg(8, 1, "R12"); strobes(1, 8, 1, "R12");
        step(1, 1, 2, 0, "R12");
        strobes(2, 2, 0, "R12");
        step(1, 1, 8, 3, "R12");
        strobes(4, 8, 3, "R12");

        // R13: user patterns ignore the format select
        fmt_twos = 1;
        cfg(8, 0, "R13"); strobes(2, 8, 0, "R13");
        cfg(8, 3, "R13"); strobes(3, 8, 3, "R13");
        fmt_twos = 0;

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule